// File: doc/BRIEF.md
# Clock Domain Gating Supervisor

This block supervises one gated clock domain. A two-bit software mode field chooses among four behaviours. The clock can be held running. Software can force the domain to sleep, and the clock is then cut once every initiator in the domain reports standby. Software can force the domain awake. In automatic mode, the clock is cut once every module is quiet and the neighbouring domains allow it. The block drives the enable of the domain's clock gate, a flag that shows the domain is running, and a flag that marks the single cycle of each sleep or wake transition.

Two parameters tailor each instance to its domain. One removes forced sleep; mode 1 then acts as mode 0. The other removes forced wake-up; mode 2 then acts as mode 0. A domain may have neither forced capability, or forced wake-up alone. Wake-up requests from other domains take priority over a forced sleep. They also take priority over the automatic gated state.

Top module: `clkdom_supervisor`

## Requirements
- R1: In mode 0 (no gating), the clock enable is never lowered. A domain that is gated or entering sleep when mode 0 takes effect has its clock restarted.
- R2: In mode 1 (forced sleep), the clock is cut once every initiator standby bit is 1 and no wake-up request is present. Module idle/standby bits and sleep-dependency bits have no effect on the cut.
- R3: In mode 2 (forced wake), the clock is restarted if it is cut and is never cut.
- R4: In mode 3 (automatic), the clock is cut once every module has its idle bit or its standby bit at 1, every sleep-dependency bit is 1, and no wake-up request is present.
- R5: In mode 1, a wake-up request restarts a cut clock on the next edge.
- R6: In mode 3, any module whose idle and standby bits are both 0, or any wake-up request, restarts a cut clock on the next edge.
- R7: With forced sleep and forced wake both disabled by parameter, modes 1 and 2 behave exactly as mode 0.
- R8: With only forced wake available, mode 1 behaves as mode 0 and mode 2 still restarts the clock.
- R9: The mode input is registered, so a new mode takes effect one edge later. The clock enable falls on the edge after the sleep condition holds, and it rises on the edge after a wake condition holds. transPending is high for exactly that one cycle, and domActive is high only when the domain is running and no transition is under way.
- R10: If the sleep condition disappears during the sleep-pending cycle, the clock enable returns to 1 on the next edge and the domain is active again.
- R11: A synchronous active-low reset sets clkEn=1, domActive=1 and transPending=0, and clears the registered mode to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| ctrlMode | input | 2 | Mode field: 0 no gating, 1 forced sleep, 2 forced wake, 3 automatic |
| modIdle | input | N_MOD | Per-module idle status |
| modStandby | input | N_MOD | Per-module standby status |
| initStandby | input | N_INIT | Per-initiator standby status |
| sleepDepOk | input | N_SDEP | 1 = that sleep dependency allows the domain to sleep |
| wakeDepReq | input | N_WDEP | 1 = that domain requests a wake-up |
| clkEn | output | 1 | Enable for the domain clock gate |
| domActive | output | 1 | Domain running, no transition under way |
| transPending | output | 1 | Sleep or wake transition cycle |

## Verification
The assertions rely on reset being applied at time zero. They also rely on all status inputs being stable around each rising edge, so the mode register and the condition logic see settled values. The bench drives every input on the falling edge. It sweeps all status patterns, both with the mode held and with the mode changing on every vector. This covers every transition from every state, including a mode change in the middle of a pending cycle. Three instances with different capability parameters receive the same stimulus.

// File: rtl/clkdom_pkg.sv
package clkdom_pkg;
  typedef enum logic [1:0] {
    MODE_NOGATE = 2'd0,
    MODE_FSLEEP = 2'd1,
    MODE_FWAKE  = 2'd2,
    MODE_AUTO   = 2'd3
  } modeT;

  typedef enum logic [1:0] {
    ST_ACTIVE     = 2'd0,
    ST_SLEEP_PEND = 2'd1,
    ST_GATED      = 2'd2,
    ST_WAKE_PEND  = 2'd3
  } stateT;

  typedef struct packed {
    logic gateNow;
    logic ungateNow;
  } strobeT;
endpackage

// File: rtl/clkdom_datapath.sv
module clkdom_datapath
  import clkdom_pkg::*;
#(
  parameter int N_MOD      = 2,
  parameter int N_INIT     = 2,
  parameter int N_SDEP     = 1,
  parameter int N_WDEP     = 1,
  parameter bit HAS_FSLEEP = 1'b1,
  parameter bit HAS_FWAKE  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        ctrlMode,
  input  logic [N_MOD-1:0]  modIdle,
  input  logic [N_MOD-1:0]  modStandby,
  input  logic [N_INIT-1:0] initStandby,
  input  logic [N_SDEP-1:0] sleepDepOk,
  input  logic [N_WDEP-1:0] wakeDepReq,
  input  strobeT            strobes,
  output logic              sleepCond,
  output logic              wakeCond,
  output logic              clkEn
);
  modeT modeEff;
  modeT modeQ;
  logic clkEnQ;

  // capability mapping: a missing forced mode degrades to no gating
  generate
    if (HAS_FSLEEP && HAS_FWAKE) begin : g_full
      assign modeEff = modeT'(ctrlMode);
    end else if (HAS_FWAKE) begin : g_wakeOnly
      assign modeEff = (modeT'(ctrlMode) == MODE_FSLEEP) ? MODE_NOGATE : modeT'(ctrlMode);
    end else if (HAS_FSLEEP) begin : g_sleepOnly
      assign modeEff = (modeT'(ctrlMode) == MODE_FWAKE) ? MODE_NOGATE : modeT'(ctrlMode);
    end else begin : g_none
      assign modeEff = (ctrlMode == 2'd3) ? MODE_AUTO : MODE_NOGATE;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= MODE_NOGATE;
    else       modeQ <= modeEff;
  end

  logic allQuiet, allInitStby, depsOk, anyWake;
  assign allQuiet    = &(modIdle | modStandby);
  assign allInitStby = &initStandby;
  assign depsOk      = &sleepDepOk;
  assign anyWake     = |wakeDepReq;

  always_comb begin
    sleepCond = 1'b0;
    wakeCond  = 1'b1;
    unique case (modeQ)
      MODE_FSLEEP: begin
        sleepCond = allInitStby && !anyWake;
        wakeCond  = anyWake;
      end
      MODE_AUTO: begin
        sleepCond = allQuiet && depsOk && !anyWake;
        wakeCond  = !allQuiet || anyWake;
      end
      default: begin
        sleepCond = 1'b0;
        wakeCond  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  clkEnQ <= 1'b1;
    else if (strobes.gateNow)   clkEnQ <= 1'b0;
    else if (strobes.ungateNow) clkEnQ <= 1'b1;
  end

  assign clkEn = clkEnQ;

  // R1: no-gating mode never cuts a running clock
  p_nogate_holds_r1: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_NOGATE && clkEnQ) |=> clkEnQ);
  // R3: forced wake never cuts a running clock
  p_fwake_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_FWAKE && clkEnQ) |=> clkEnQ);
  // R5: wake request during forced sleep restarts the clock
  p_fsleep_wake_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnQ && modeQ == MODE_FSLEEP && anyWake) |=> clkEnQ);
  // R6: activity or wake request in automatic mode restarts the clock
  p_auto_wake_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnQ && modeQ == MODE_AUTO && (!allQuiet || anyWake)) |=> clkEnQ);
endmodule

// File: rtl/clkdom_control.sv
module clkdom_control
  import clkdom_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sleepCond,
  input  logic   wakeCond,
  output strobeT strobes,
  output logic   domActive,
  output logic   transPending
);
  stateT state, stateNext;

  always_comb begin
    stateNext         = state;
    strobes.gateNow   = 1'b0;
    strobes.ungateNow = 1'b0;
    unique case (state)
      ST_ACTIVE: if (sleepCond) begin
        stateNext       = ST_SLEEP_PEND;
        strobes.gateNow = 1'b1;
      end
      ST_SLEEP_PEND: if (sleepCond) begin
        stateNext = ST_GATED;
      end else begin
        stateNext         = ST_ACTIVE;
        strobes.ungateNow = 1'b1;
      end
      ST_GATED: if (wakeCond) begin
        stateNext         = ST_WAKE_PEND;
        strobes.ungateNow = 1'b1;
      end
      default: stateNext = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_ACTIVE;
    else       state <= stateNext;
  end

  assign domActive    = (state == ST_ACTIVE);
  assign transPending = (state == ST_SLEEP_PEND) || (state == ST_WAKE_PEND);

  // R9: a transition cycle never repeats back to back
  p_pending_one_cycle_r9: assert property (@(posedge clk) disable iff (!rstN)
    transPending |=> !transPending);
  // R9: sleep condition while active opens a pending cycle on the next edge
  p_sleep_enters_r9: assert property (@(posedge clk) disable iff (!rstN)
    (domActive && sleepCond) |=> (transPending && !domActive));
endmodule

// File: rtl/clkdom_supervisor.sv
module clkdom_supervisor
  import clkdom_pkg::*;
#(
  parameter int N_MOD      = 2,
  parameter int N_INIT     = 2,
  parameter int N_SDEP     = 1,
  parameter int N_WDEP     = 1,
  parameter bit HAS_FSLEEP = 1'b1,
  parameter bit HAS_FWAKE  = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        ctrlMode,
  input  logic [N_MOD-1:0]  modIdle,
  input  logic [N_MOD-1:0]  modStandby,
  input  logic [N_INIT-1:0] initStandby,
  input  logic [N_SDEP-1:0] sleepDepOk,
  input  logic [N_WDEP-1:0] wakeDepReq,
  output logic              clkEn,
  output logic              domActive,
  output logic              transPending
);
  strobeT strobes;
  logic   sleepCond, wakeCond;

  clkdom_datapath #(
    .N_MOD(N_MOD), .N_INIT(N_INIT), .N_SDEP(N_SDEP), .N_WDEP(N_WDEP),
    .HAS_FSLEEP(HAS_FSLEEP), .HAS_FWAKE(HAS_FWAKE)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctrlMode(ctrlMode), .modIdle(modIdle),
    .modStandby(modStandby), .initStandby(initStandby), .sleepDepOk(sleepDepOk),
    .wakeDepReq(wakeDepReq), .strobes(strobes), .sleepCond(sleepCond),
    .wakeCond(wakeCond), .clkEn(clkEn)
  );

  clkdom_control ctl_i (
    .clk(clk), .rstN(rstN), .sleepCond(sleepCond), .wakeCond(wakeCond),
    .strobes(strobes), .domActive(domActive), .transPending(transPending)
  );

  // R11: reset leaves the domain running with no transition
  p_reset_state_r11: assert property (@(posedge clk)
    !rstN |=> (clkEn && domActive && !transPending));
  // R9: the clock is cut only while not reported active
  p_active_runs_r9: assert property (@(posedge clk) disable iff (!rstN)
    domActive |-> clkEn);
endmodule

// File: tb/clkdom_supervisor_tb_top.sv
module clkdom_supervisor_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] ctrlMode = 2'd0;
  logic [1:0] modIdle = '0, modStandby = '0, initStandby = '0;
  logic [0:0] sleepDepOk = '0, wakeDepReq = '0;
  logic [2:0] clkEnV, actV, pendV;
  int vectors = 0;
  int miscompares = 0;
  string curTag = "";

  always #2 clk = ~clk;

  clkdom_supervisor #(.HAS_FSLEEP(1'b1), .HAS_FWAKE(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .ctrlMode(ctrlMode), .modIdle(modIdle), .modStandby(modStandby),
    .initStandby(initStandby), .sleepDepOk(sleepDepOk), .wakeDepReq(wakeDepReq),
    .clkEn(clkEnV[0]), .domActive(actV[0]), .transPending(pendV[0]));
  clkdom_supervisor #(.HAS_FSLEEP(1'b0), .HAS_FWAKE(1'b0)) dut_none_i (
    .clk(clk), .rstN(rstN), .ctrlMode(ctrlMode), .modIdle(modIdle), .modStandby(modStandby),
    .initStandby(initStandby), .sleepDepOk(sleepDepOk), .wakeDepReq(wakeDepReq),
    .clkEn(clkEnV[1]), .domActive(actV[1]), .transPending(pendV[1]));
  clkdom_supervisor #(.HAS_FSLEEP(1'b0), .HAS_FWAKE(1'b1)) dut_wake_i (
    .clk(clk), .rstN(rstN), .ctrlMode(ctrlMode), .modIdle(modIdle), .modStandby(modStandby),
    .initStandby(initStandby), .sleepDepOk(sleepDepOk), .wakeDepReq(wakeDepReq),
    .clkEn(clkEnV[2]), .domActive(actV[2]), .transPending(pendV[2]));

  // requirement model: states 0 active, 1 sleep pending, 2 gated, 3 wake pending
  logic [1:0] mQ [3];
  logic [1:0] stM [3];
  logic       enM [3];

  function automatic logic [1:0] effMode(logic [1:0] raw, int c);
    if (raw == 2'd1 && c != 0) return 2'd0;
    if (raw == 2'd2 && c == 1) return 2'd0;
    return raw;
  endfunction

  function automatic logic sleepOk(logic [1:0] m);
    if (m == 2'd1) return (initStandby == 2'b11) && (wakeDepReq == 1'b0);
    if (m == 2'd3) return ((modIdle | modStandby) == 2'b11) && sleepDepOk[0] && !wakeDepReq[0];
    return 1'b0;
  endfunction

  function automatic logic wakeOk(logic [1:0] m);
    if (m == 2'd1) return wakeDepReq[0];
    if (m == 2'd3) return ((modIdle | modStandby) != 2'b11) || wakeDepReq[0];
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < 3; c++) begin
      if (!rstN) begin
        mQ[c] <= 2'd0; stM[c] <= 2'd0; enM[c] <= 1'b1;
      end else begin
        mQ[c] <= effMode(ctrlMode, c);
        case (stM[c])
          2'd0: if (sleepOk(mQ[c])) begin stM[c] <= 2'd1; enM[c] <= 1'b0; end
          2'd1: if (sleepOk(mQ[c])) stM[c] <= 2'd2;
                else begin stM[c] <= 2'd0; enM[c] <= 1'b1; end
          2'd2: if (wakeOk(mQ[c])) begin stM[c] <= 2'd3; enM[c] <= 1'b1; end
          default: stM[c] <= 2'd0;
        endcase
      end
    end
  end

  task automatic checkBit(string tag, string what, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0b expected %0b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  function automatic string autoTag(int c);
    if (c == 1 && (ctrlMode == 2'd1 || ctrlMode == 2'd2)) return "R7";
    if (c == 2 && (ctrlMode == 2'd1 || ctrlMode == 2'd2)) return "R8";
    case (ctrlMode)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic checkAll();
    for (int c = 0; c < 3; c++) begin
      string t = (curTag != "") ? curTag : autoTag(c);
      checkBit(t, "clkEn", clkEnV[c], enM[c]);
      checkBit((curTag != "") ? curTag : "R9", "domActive", actV[c], stM[c] == 2'd0);
      checkBit((curTag != "") ? curTag : "R9", "transPending", pendV[c],
               stM[c] == 2'd1 || stM[c] == 2'd3);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk); @(negedge clk);
      checkAll();
    end
  endtask

  task automatic drive(logic [7:0] v);
    {modIdle, modStandby, initStandby, sleepDepOk, wakeDepReq} = v;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    for (int c = 0; c < 3; c++) begin
      checkBit("R11", "clkEn", clkEnV[c], 1'b1);
      checkBit("R11", "domActive", actV[c], 1'b1);
      checkBit("R11", "transPending", pendV[c], 1'b0);
    end
    rstN = 1'b1;
    step(2);

    // sweep with mode held
    for (int m = 0; m < 4; m++) begin
      ctrlMode = 2'(m);
      for (int v = 0; v < 256; v++) begin
        drive(8'(v));
        step(2);
      end
    end
    // sweep with mode changing every vector
    for (int v = 0; v < 1024; v++) begin
      ctrlMode = 2'(v);
      drive(8'(v >> 2));
      step(3);
    end

    // R2 forced sleep ignores module and sleep-dependency bits
    curTag = "R2";
    ctrlMode = 2'd0; drive(8'h00); step(3);
    ctrlMode = 2'd1; modIdle = 2'b00; modStandby = 2'b00; sleepDepOk = 1'b0;
    initStandby = 2'b11; wakeDepReq = 1'b0;
    step(2);
    checkBit("R2", "clkEn", clkEnV[0], 1'b0);
    step(1);
    // R5 wake request in forced sleep
    curTag = "R5";
    wakeDepReq = 1'b1; step(1);
    checkBit("R5", "clkEn", clkEnV[0], 1'b1);

    // R6 activity in automatic gated state
    curTag = "R6";
    ctrlMode = 2'd3; drive(8'b11_00_00_1_0); step(4);
    checkBit("R6", "clkEn gated", clkEnV[0], 1'b0);
    modIdle = 2'b10; step(1);
    checkBit("R6", "clkEn", clkEnV[0], 1'b1);

    // R10 abort during sleep pending
    curTag = "R10";
    ctrlMode = 2'd0; step(3);
    ctrlMode = 2'd3; modIdle = 2'b11; step(2);
    checkBit("R10", "transPending", pendV[0], 1'b1);
    checkBit("R10", "clkEn pend", clkEnV[0], 1'b0);
    modIdle = 2'b00; step(1);
    checkBit("R10", "clkEn", clkEnV[0], 1'b1);
    checkBit("R10", "domActive", actV[0], 1'b1);

    // R11 reset from gated state
    curTag = "R11";
    modIdle = 2'b11; step(4);
    rstN = 1'b0; step(1);
    checkBit("R11", "clkEn", clkEnV[0], 1'b1);
    rstN = 1'b1; curTag = "";

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule